// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of a general-purpose timer, together with the timer's own prescaled up-counter. The counter advances once every (prescale + 1) enabled clock cycles and returns to zero after reaching the reload value. The channel compares the counter against an active compare value. A match either leaves the reference waveform alone, sets it, clears it or inverts it, depending on the selected mode. Two further modes hold the reference at a fixed level whatever the counter does.

The reference waveform is held in a two-state machine with the states `REF_LOW` and `REF_HIGH`. Each mode has its own rules for moving between them. In set mode a match moves `REF_LOW -> REF_HIGH`, and in clear mode it moves `REF_HIGH -> REF_LOW`. In toggle mode a match swaps the state either way. Forced-low mode enters `REF_LOW` on every cycle and forced-high mode enters `REF_HIGH` on every cycle. Timing mode and the unused codes always stay in the current state. A match also raises a sticky flag, which can raise an interrupt request.

The pin output is the reference, inverted when the polarity bit asks for it, and it is gated by a channel enable. The compare value is either loaded directly, or held in a shadow register and moved to the active register on an update event.

Top module: `oc_channel`

## Requirements
- R1: `cnt_o` resets to 0. While `cnt_en` is high it advances by one after every `psc`+1 enabled cycles. When it advances from a value at or above `reload` it returns to 0. While `cnt_en` is low it and the prescale phase hold.
- R2: With `mode` 0 (timing), or the unused codes 6 and 7, `ref_o` never changes. In these modes `pin_o` equals `ref_o` regardless of `pol` while `chan_en` is high.
- R3: With `mode` 1 (set on match), `ref_o` becomes 1 on the same clock edge at which `cnt_o` takes the active compare value.
- R4: With `mode` 2 (clear on match), `ref_o` becomes 0 on the edge at which `cnt_o` takes the active compare value.
- R5: With `mode` 3 (toggle on match), `ref_o` inverts on each edge at which `cnt_o` takes the active compare value.
- R6: With `mode` 4, `ref_o` is 0 from the next edge on. With `mode` 5, it is 1 from the next edge on. The counter has no effect in either mode.
- R7: With `mode` 1 to 5 and `chan_en` high, `pin_o` equals `ref_o` XOR `pol`.
- R8: With `chan_en` low, `pin_o` equals `pol`, its inactive level. `ref_o` keeps following its mode rules.
- R9: With `preload_en` low, a `cmp_wr` pulse makes `cmp_val` the active compare value from the next cycle on.
- R10: With `preload_en` high, a `cmp_wr` pulse only loads a shadow register. The shadow register becomes active at the next update event, which is a counter wrap or a `sw_update` pulse.
- R11: `match_flag` is set by any match, in any mode. It stays set until a `flag_clr` pulse. A match in the same cycle as a clear wins.
- R12: `irq_o` equals `match_flag` AND `irq_en`.
- R13: After reset `ref_o` and `match_flag` are 0 and the active compare value is 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter run enable |
| psc | input | PSC_W | Prescale value; the counter ticks every psc+1 cycles |
| reload | input | CNT_W | Top count before the counter wraps to 0 |
| cmp_val | input | CNT_W | Compare value to write |
| cmp_wr | input | 1 | Write strobe for cmp_val |
| preload_en | input | 1 | 1: writes go through the shadow register |
| sw_update | input | 1 | Software update event pulse |
| mode | input | 3 | Compare mode (0 timing, 1 set, 2 clear, 3 toggle, 4 forced low, 5 forced high) |
| pol | input | 1 | 1: pin is the inverse of the reference |
| chan_en | input | 1 | Channel output enable |
| flag_clr | input | 1 | Clears the match flag |
| irq_en | input | 1 | Interrupt enable |
| cnt_o | output | CNT_W | Counter value |
| ref_o | output | 1 | Reference waveform |
| pin_o | output | 1 | Pin output after polarity and enable |
| match_flag | output | 1 | Sticky match flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong reference state appears on `ref_o` and `pin_o` on the first cycle after the edge that corrupted it. A missed or extra match shows up no later than the next time the counter reaches the compare value. The most common way it shows is a toggle waveform that stays inverted from then on. A wrong active compare value is not visible until the counter reaches the old or the new value. For this reason the preload cases are checked at a count between the two values, and then again after the wrap. A wrong prescale phase shows as a counter that advances one cycle early or late, and a per-cycle comparison catches this on the very next tick.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [2:0] {
        OCM_TIMING   = 3'd0,
        OCM_SET      = 3'd1,
        OCM_CLEAR    = 3'd2,
        OCM_TOGGLE   = 3'd3,
        OCM_FORCE_LO = 3'd4,
        OCM_FORCE_HI = 3'd5
    } oc_mode_e;

    typedef enum logic {
        REF_LOW  = 1'b0,
        REF_HIGH = 1'b1
    } ref_state_e;

endpackage

// File: rtl/oc_timebase.sv
module oc_timebase #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PSC_W-1:0] psc,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             tick,
    output logic             wrap
);

    logic [PSC_W-1:0] phase;
    logic             at_top;

    assign at_top  = (cnt >= reload);
    assign tick    = en && (phase >= psc);
    assign wrap    = tick && at_top;
    assign cnt_nxt = at_top ? '0 : cnt + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
            cnt   <= '0;
        end else if (en) begin
            if (tick) begin
                phase <= '0;
                cnt   <= cnt_nxt;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

endmodule

// File: rtl/oc_cmp_hold.sv
module oc_cmp_hold #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             preload,
    input  logic             upd,
    output logic [CNT_W-1:0] active
);

    logic [CNT_W-1:0] shadow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
            active <= '0;
        end else begin
            if (wr) begin
                shadow <= wr_val;
            end
            if (wr && !preload) begin
                active <= wr_val;
            end else if (upd && preload) begin
                active <= shadow;
            end
        end
    end

endmodule

// File: rtl/oc_ref_fsm.sv
module oc_ref_fsm
    import oc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       hit,
    output logic       ref_o
);

    ref_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= REF_LOW;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (mode)
            OCM_SET:      if (hit) state_nxt = REF_HIGH;
            OCM_CLEAR:    if (hit) state_nxt = REF_LOW;
            OCM_TOGGLE:   if (hit) state_nxt = (state == REF_HIGH) ? REF_LOW : REF_HIGH;
            OCM_FORCE_LO: state_nxt = REF_LOW;
            OCM_FORCE_HI: state_nxt = REF_HIGH;
            default:      state_nxt = state;
        endcase
    end

    always_comb begin
        ref_o = (state == REF_HIGH);
    end

endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [PSC_W-1:0] psc,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cmp_wr,
    input  logic             preload_en,
    input  logic             sw_update,
    input  logic [2:0]       mode,
    input  logic             pol,
    input  logic             chan_en,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ref_o,
    output logic             pin_o,
    output logic             match_flag,
    output logic             irq_o
);

    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] cmp_act;
    logic             tick;
    logic             wrap;
    logic             hit;
    logic             polar_mode;

    oc_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cnt_en),
        .psc     (psc),
        .reload  (reload),
        .cnt     (cnt_o),
        .cnt_nxt (cnt_nxt),
        .tick    (tick),
        .wrap    (wrap)
    );

    oc_cmp_hold #(.CNT_W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cmp_wr),
        .wr_val  (cmp_val),
        .preload (preload_en),
        .upd     (wrap || sw_update),
        .active  (cmp_act)
    );

    assign hit = tick && (cnt_nxt == cmp_act);

    oc_ref_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .hit   (hit),
        .ref_o (ref_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_flag <= 1'b0;
        end else if (hit) begin
            match_flag <= 1'b1;
        end else if (flag_clr) begin
            match_flag <= 1'b0;
        end
    end

    always_comb begin
        polar_mode = (mode >= OCM_SET) && (mode <= OCM_FORCE_HI);
        if (!chan_en) begin
            pin_o = pol;
        end else if (polar_mode) begin
            pin_o = ref_o ^ pol;
        end else begin
            pin_o = ref_o;
        end
        irq_o = match_flag && irq_en;
    end

endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode,
    input logic             hit,
    input logic             ref_o,
    input logic             match_flag,
    input logic             flag_clr,
    input logic [CNT_W-1:0] cnt_o
);

    p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_o) |-> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)) || (cnt_o == '0));

    p_timing_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0) |=> (ref_o == $past(ref_o)));

    p_set_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1 && hit) |=> ref_o);

    p_clear_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 && hit) |=> !ref_o);

    p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && hit) |=> (ref_o != $past(ref_o)));

    p_force_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4) |=> !ref_o);

    p_force_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd5) |=> ref_o);

    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !flag_clr) |=> match_flag);

    p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> match_flag);

endmodule

bind oc_channel oc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .hit        (hit),
    .ref_o      (ref_o),
    .match_flag (match_flag),
    .flag_clr   (flag_clr),
    .cnt_o      (cnt_o)
);

// File: tb/oc_channel_bench.sv
module oc_channel_bench;

    localparam int CNT_W = 16;
    localparam int PSC_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cnt_en = 1'b0;
    logic [PSC_W-1:0] psc = '0;
    logic [CNT_W-1:0] reload = '0;
    logic [CNT_W-1:0] cmp_val = '0;
    logic             cmp_wr = 1'b0;
    logic             preload_en = 1'b0;
    logic             sw_update = 1'b0;
    logic [2:0]       mode = 3'd0;
    logic             pol = 1'b0;
    logic             chan_en = 1'b1;
    logic             flag_clr = 1'b0;
    logic             irq_en = 1'b0;
    logic [CNT_W-1:0] cnt_o;
    logic             ref_o;
    logic             pin_o;
    logic             match_flag;
    logic             irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    int m_cnt, m_pc, m_cmp, m_shadow;
    bit m_ref, m_flag;

    always #5 clk = ~clk;

    oc_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_oc_channel (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .psc(psc), .reload(reload),
        .cmp_val(cmp_val), .cmp_wr(cmp_wr), .preload_en(preload_en),
        .sw_update(sw_update), .mode(mode), .pol(pol), .chan_en(chan_en),
        .flag_clr(flag_clr), .irq_en(irq_en), .cnt_o(cnt_o), .ref_o(ref_o),
        .pin_o(pin_o), .match_flag(match_flag), .irq_o(irq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string ref_tag(input logic [2:0] md);
        case (md)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4, 3'd5: return "R6";
            default: return "R2";
        endcase
    endfunction

    function automatic bit exp_pin(input bit r);
        if (!chan_en) return pol;
        if (mode >= 3'd1 && mode <= 3'd5) return r ^ pol;
        return r;
    endfunction

    task automatic model_step();
        bit tick, hit, upd;
        int nxt;
        tick = cnt_en && (m_pc >= int'(psc));
        nxt  = (m_cnt >= int'(reload)) ? 0 : m_cnt + 1;
        hit  = tick && (nxt == m_cmp);
        upd  = (tick && m_cnt >= int'(reload)) || sw_update;
        if (cnt_en) m_pc = tick ? 0 : m_pc + 1;
        if (tick) m_cnt = nxt;
        if (cmp_wr && !preload_en) m_cmp = int'(cmp_val);
        else if (upd && preload_en) m_cmp = m_shadow;
        if (cmp_wr) m_shadow = int'(cmp_val);
        case (mode)
            3'd1: if (hit) m_ref = 1'b1;
            3'd2: if (hit) m_ref = 1'b0;
            3'd3: if (hit) m_ref = ~m_ref;
            3'd4: m_ref = 1'b0;
            3'd5: m_ref = 1'b1;
            default: ;
        endcase
        if (hit) m_flag = 1'b1;
        else if (flag_clr) m_flag = 1'b0;
    endtask

    task automatic compare_all();
        chk("R1 cnt", int'(cnt_o), m_cnt);
        chk({ref_tag(mode), " ref"}, int'(ref_o), int'(m_ref));
        chk(chan_en ? "R7 pin" : "R8 pin", int'(pin_o), int'(exp_pin(m_ref)));
        chk("R11 flag", int'(match_flag), int'(m_flag));
        chk("R12 irq", int'(irq_o), int'(m_flag && irq_en));
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic run_to(input int v);
        while (m_cnt != v) cycle();
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        m_cnt = 0; m_pc = 0; m_cmp = 0; m_shadow = 0; m_ref = 0; m_flag = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R13 reset state
        chk("R13 cnt", int'(cnt_o), 0);
        chk("R13 ref", int'(ref_o), 0);
        chk("R13 flag", int'(match_flag), 0);
        chk("R13 pin", int'(pin_o), 0);

        // R9 direct write
        psc = 8'd1; reload = 16'd15; cnt_en = 1'b1; mode = 3'd4;
        cmp_val = 16'd9; cmp_wr = 1'b1; cycle(); cmp_wr = 1'b0;
        run_to(3);
        mode = 3'd1;
        run_to(8);
        chk("R3 ref before match", int'(ref_o), 0);
        run_to(9);
        chk("R9 ref at new compare", int'(ref_o), 1);
        chk("R11 flag on match", int'(match_flag), 1);
        flag_clr = 1'b1; cycle(); flag_clr = 1'b0;
        chk("R11 flag cleared", int'(match_flag), 0);

        // R10 preload
        irq_en = 1'b1; mode = 3'd4; cycle(); mode = 3'd1; preload_en = 1'b1;
        run_to(2);
        cmp_val = 16'd5; cmp_wr = 1'b1; cycle(); cmp_wr = 1'b0;
        run_to(6);
        chk("R10 ref before update", int'(ref_o), 0);
        run_to(0);
        run_to(5);
        chk("R10 ref after update", int'(ref_o), 1);
        chk("R12 irq", int'(irq_o), 1);

        // R7 / R8 / R2
        pol = 1'b1; cycle();
        chk("R7 pin inverted", int'(pin_o), 0);
        chan_en = 1'b0; mode = 3'd4; cycle();
        chk("R8 pin idle", int'(pin_o), 1);
        chk("R8 ref still tracked", int'(ref_o), 0);
        chan_en = 1'b1; mode = 3'd5; cycle();
        chk("R6 forced high", int'(ref_o), 1);
        mode = 3'd0; cycle();
        chk("R2 pin ignores pol", int'(pin_o), 1);
        cnt_en = 1'b0; repeat (4) cycle();
        chk("R1 hold when stopped", int'(cnt_o), m_cnt);
        cnt_en = 1'b1;

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 99) < 4) begin
                mode       = 3'($urandom_range(0, 7));
                pol        = 1'($urandom_range(0, 1));
                chan_en    = ($urandom_range(0, 9) != 0);
                preload_en = 1'($urandom_range(0, 1));
                irq_en     = 1'($urandom_range(0, 1));
                psc        = PSC_W'($urandom_range(0, 2));
                reload     = CNT_W'($urandom_range(3, 20));
                cnt_en     = ($urandom_range(0, 9) != 0);
            end
            cmp_wr    = ($urandom_range(0, 99) < 5);
            cmp_val   = CNT_W'($urandom_range(0, 20));
            sw_update = ($urandom_range(0, 99) < 3);
            flag_clr  = ($urandom_range(0, 99) < 6);
            cycle();
        end
        cmp_wr = 1'b0; sw_update = 1'b0; flag_clr = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule